// File: doc/BRIEF.md
# Per-CPU Soft Interrupt and Level Combiner

This block is the register bank that sits in front of one processor's interrupt input. It keeps a 32-bit local pending word. The word holds fifteen software-raised interrupts in its top bits, one bit that tracks a shared level-15 line, and one bit that tracks this processor's private timer line. Every clock, the block merges that word with the already-routed hard-level vector from the system router. The result is a registered 15-bit level vector, with bit n meaning level n is requested. Levels 1 to 15 exist. Level 0 does not.

Software uses a word-wide register port that selects one of four word slots. The slot index times four gives the byte offset. Slot 0 reads the pending word. Slot 1 clears bits and slot 2 sets bits. Slot 3 is unused. The router supplies two views of the hard levels. One is unfiltered, for display in the pending word. The other is already filtered, for delivery. The router also supplies a global master-off flag. That flag silences the timer and level-15 paths but leaves software interrupts and delivered hard levels alone.

Top module: `cpu_irq_bank`

## Requirements
- R1: While reset is low and after its release, the pending word is 0 and the level output is 0.
- R2: A read of slot 0 returns this layout: bits 31:17 soft pending, bit 16 zero, bit 15 level-15 latch, bit 14 timer, bits 13:1 the unfiltered hard levels 13:1 (`hardShown`), bit 0 zero. Reads of slots 1, 2 and 3 return 0. Read data is valid in the same cycle as the read request.
- R3: A write to slot 2 ORs write-data bits 31:17 into the soft pending bits. All other write-data bits have no effect.
- R4: A write to slot 1 clears every soft pending bit whose write-data bit (31:17) is 1, and clears bit 15 when write-data bit 15 is 1. Bit 14 is never cleared by software.
- R5: Pending bit 14 equals the timer input as sampled at the previous clock edge.
- R6: Pending bit 15 is set when the level-15 input rises and cleared when it falls. Software may clear it while the input stays high. If a clear and a rising edge meet in the same cycle, the bit ends up set.
- R7: The level output, bit n for level n, is registered. One clock after the pending word and the inputs are seen, it equals: the delivered hard levels OR soft pending bits 31:17 (placed on levels 15:1) OR pending bits 15:14 (placed on levels 15:14) when master-off is low.
- R8: While master-off is high, pending bits 15 and 14 do not reach the output. Soft bits and delivered hard levels still do.
- R9: A write to slot 3 changes no state. It is observed through a later read of slot 0 and through the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access request this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regSel | input | 2 | Word slot (byte offset / 4) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, same cycle |
| timerIn | input | 1 | This CPU's timer interrupt level |
| lvl15In | input | 1 | Broadcast level-15 interrupt line |
| masterOff | input | 1 | Global master disable from the router |
| hardLevels | input | 15 | Filtered hard levels 15:1 for delivery |
| hardShown | input | 13 | Unfiltered hard levels 13:1 for display |
| irlOut | output | 15 | Registered level request vector, levels 15:1 |

## Verification
The hardest case to reach from the ports is a software clear of bit 15 that lands in the same cycle as a fresh rising edge on the level-15 line. It is hardest because the edge detector only fires once per transition. The directed stimulus first drops the line for one cycle. It then raises the line and issues the clear together, and reads the word back. A second hard case is master-off hiding a bit 15 or bit 14 that is still pending. The stimulus pairs master-off with both local sources asserted and soft bits set, so that only the gating separates the outcomes. A long random run then mixes slot accesses, line toggles and master-off flips against a cycle model of the word.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;
  localparam int WORD_W    = 32;
  localparam int LVL_HI    = 15;
  localparam int SOFT_LO   = 17;
  localparam int SOFT_W    = WORD_W - SOFT_LO;
  localparam int L15_BIT   = 15;
  localparam int TIMER_BIT = 14;
  localparam int SHOWN_HI  = 13;
  localparam int SEL_W     = 2;

  localparam logic [WORD_W-1:0] SOFT_MASK = {{SOFT_W{1'b1}}, {SOFT_LO{1'b0}}};
  localparam logic [WORD_W-1:0] CLR_MASK  = SOFT_MASK | (32'd1 << L15_BIT);
  localparam logic [WORD_W-1:0] KEEP_MASK = CLR_MASK | (32'd1 << TIMER_BIT);

  localparam logic [SEL_W-1:0] SLOT_READ = 2'd0;
  localparam logic [SEL_W-1:0] SLOT_CLR  = 2'd1;
  localparam logic [SEL_W-1:0] SLOT_SET  = 2'd2;

  typedef struct packed {
    logic rdWord;
    logic clrBits;
    logic setBits;
  } bankStrobes_t;
endpackage

// File: rtl/cpu_irq_decode.sv
module cpu_irq_decode
  import cpu_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regValid,
  input  logic             regWrite,
  input  logic [SEL_W-1:0] regSel,
  output bankStrobes_t     strobes
);
  always_comb begin
    strobes.rdWord  = regValid && !regWrite && (regSel == SLOT_READ);
    strobes.clrBits = regValid &&  regWrite && (regSel == SLOT_CLR);
    strobes.setBits = regValid &&  regWrite && (regSel == SLOT_SET);
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.rdWord, strobes.clrBits, strobes.setBits})); // R2
  AST_SLOT3_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 2'd3) |-> !(strobes.clrBits || strobes.setBits || strobes.rdWord)); // R9
endmodule

// File: rtl/cpu_irq_pending.sv
module cpu_irq_pending
  import cpu_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  bankStrobes_t       strobes,
  input  logic [WORD_W-1:0]  regWdata,
  input  logic               timerIn,
  input  logic               lvl15In,
  input  logic [SHOWN_HI:1]  hardShown,
  output logic [WORD_W-1:0]  regRdata,
  output logic [SOFT_W-1:0]  softPend,
  output logic [1:0]         localPend
);
  logic [WORD_W-1:0] pendReg;
  logic [WORD_W-1:0] pendNext;
  logic [WORD_W-1:0] shownWord;
  logic              l15Prev;
  logic              l15Rise;
  logic              l15Fall;

  assign l15Rise = lvl15In && !l15Prev;
  assign l15Fall = !lvl15In && l15Prev;

  always_comb begin
    pendNext = pendReg;
    if (strobes.clrBits) pendNext = pendNext & ~(regWdata & CLR_MASK);
    if (strobes.setBits) pendNext = pendNext | (regWdata & SOFT_MASK);
    pendNext = pendNext & KEEP_MASK;
    pendNext[TIMER_BIT] = timerIn;
    if (l15Rise)      pendNext[L15_BIT] = 1'b1;
    else if (l15Fall) pendNext[L15_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendReg <= '0;
      l15Prev <= 1'b0;
    end else begin
      pendReg <= pendNext;
      l15Prev <= lvl15In;
    end
  end

  assign shownWord = {{(WORD_W-SHOWN_HI-1){1'b0}}, hardShown, 1'b0};
  assign regRdata  = strobes.rdWord ? (pendReg | shownWord) : '0;
  assign softPend  = pendReg[WORD_W-1:SOFT_LO];
  assign localPend = {pendReg[L15_BIT], pendReg[TIMER_BIT]};

  AST_TIMER_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (localPend[0] == $past(timerIn))); // R5
  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setBits |=> ((softPend & $past(softPend)) == $past(softPend))); // R3
  AST_IDLE_SOFT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.setBits || strobes.clrBits) |=> $stable(softPend)); // R9
  AST_RISE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    l15Rise |=> localPend[1]); // R6
endmodule

// File: rtl/cpu_irq_merge.sv
module cpu_irq_merge
  import cpu_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SOFT_W-1:0] softPend,
  input  logic [1:0]        localPend,
  input  logic              masterOff,
  input  logic [LVL_HI:1]   hardLevels,
  output logic [LVL_HI:1]   irlOut
);
  logic [LVL_HI:1] localLvls;
  logic [LVL_HI:1] irlNext;

  always_comb begin
    localLvls = '0;
    if (!masterOff) begin
      localLvls[L15_BIT]   = localPend[1];
      localLvls[TIMER_BIT] = localPend[0];
    end
    irlNext = hardLevels | softPend | localLvls;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irlOut <= '0;
    else       irlOut <= irlNext;
  end

  AST_SOFT_REACHES: assert property (@(posedge clk) disable iff (!rstN)
    softPend[SOFT_W-1] |=> irlOut[LVL_HI]); // R7
  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (masterOff && !hardLevels[TIMER_BIT] && !softPend[TIMER_BIT-1]) |=> !irlOut[TIMER_BIT]); // R8
endmodule

// File: rtl/cpu_irq_bank.sv
module cpu_irq_bank
  import cpu_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [1:0]        regSel,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              timerIn,
  input  logic              lvl15In,
  input  logic              masterOff,
  input  logic [15:1]       hardLevels,
  input  logic [13:1]       hardShown,
  output logic [15:1]       irlOut
);
  bankStrobes_t      strobes;
  logic [SOFT_W-1:0] softPend;
  logic [1:0]        localPend;

  cpu_irq_decode uDecode (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regSel(regSel), .strobes(strobes)
  );

  cpu_irq_pending uPending (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWdata(regWdata),
    .timerIn(timerIn), .lvl15In(lvl15In), .hardShown(hardShown),
    .regRdata(regRdata), .softPend(softPend), .localPend(localPend)
  );

  cpu_irq_merge uMerge (
    .clk(clk), .rstN(rstN), .softPend(softPend), .localPend(localPend),
    .masterOff(masterOff), .hardLevels(hardLevels), .irlOut(irlOut)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (irlOut == '0)); // R1
endmodule

// File: tb/cpu_irq_bank_test.sv
module cpu_irq_bank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0, regWrite = 1'b0;
  logic [1:0]  regSel = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        timerIn = 1'b0, lvl15In = 1'b0, masterOff = 1'b0;
  logic [15:1] hardLevels = '0;
  logic [13:1] hardShown = '0;
  logic [15:1] irlOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [14:0] mSoft = '0;
  logic        mB15 = 1'b0, mB14 = 1'b0, mPrev15 = 1'b0;
  logic [15:1] mIrl = '0;

  cpu_irq_bank uut (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] expRead(input logic [1:0] sel, input logic [13:1] shown);
    if (sel != 2'd0) return 32'd0;
    return {mSoft, 1'b0, mB15, mB14, shown, 1'b0};
  endfunction

  function automatic logic [15:1] expIrl(input logic [15:1] hard, input logic off);
    logic [15:1] v;
    v = hard | mSoft;
    if (!off) begin v[15] = v[15] | mB15; v[14] = v[14] | mB14; end
    return v;
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doCycle(input string tag, input logic v, input logic w, input logic [1:0] s,
                         input logic [31:0] d, input logic t, input logic l, input logic off,
                         input logic [15:1] hard, input logic [13:1] shown);
    @(negedge clk);
    regValid = v; regWrite = w; regSel = s; regWdata = d;
    timerIn = t; lvl15In = l; masterOff = off; hardLevels = hard; hardShown = shown;
    #1;
    check32({tag, " irl"}, {17'd0, irlOut}, {17'd0, mIrl});
    if (v && !w) check32({tag, " read"}, regRdata, expRead(s, shown));
    @(posedge clk);
    mIrl = expIrl(hard, off);
    if (v && w && s == 2'd2) mSoft = mSoft | d[31:17];
    if (v && w && s == 2'd1) begin
      mSoft = mSoft & ~d[31:17];
      if (d[15]) mB15 = 1'b0;
    end
    mB14 = t;
    if (l && !mPrev15) mB15 = 1'b1;
    else if (!l && mPrev15) mB15 = 1'b0;
    mPrev15 = l;
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 check32("R1 in reset irl", {17'd0, irlOut}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    doCycle("R1", 1, 0, 2'd0, 0, 0, 0, 0, '0, '0);
    doCycle("R1", 1, 0, 2'd0, 0, 0, 0, 0, '0, '0);
    doCycle("R3", 1, 1, 2'd2, 32'hFFFF_FFFF, 0, 0, 0, '0, '0);
    doCycle("R3", 1, 0, 2'd0, 0, 0, 0, 0, '0, '0);
    doCycle("R7", 1, 0, 2'd0, 0, 0, 0, 0, '0, 13'h0AAA);
    doCycle("R4", 1, 1, 2'd1, 32'hAAAA_0000, 0, 0, 0, '0, '0);
    doCycle("R4", 1, 0, 2'd0, 0, 0, 0, 0, '0, '0);
    doCycle("R4", 1, 1, 2'd1, 32'hFFFF_FFFF, 1, 0, 0, '0, '0);
    doCycle("R5", 1, 0, 2'd0, 0, 1, 0, 0, '0, '0);
    doCycle("R5", 1, 1, 2'd1, 32'hFFFF_FFFF, 1, 0, 0, '0, '0);
    doCycle("R5", 1, 0, 2'd0, 0, 0, 1, 0, '0, '0);
    doCycle("R6", 1, 0, 2'd0, 0, 0, 1, 0, '0, '0);
    doCycle("R6", 1, 1, 2'd1, 32'h0000_8000, 0, 1, 0, '0, '0);
    doCycle("R6", 1, 0, 2'd0, 0, 0, 1, 0, '0, '0);
    doCycle("R6", 1, 0, 2'd0, 0, 0, 0, 0, '0, '0);
    doCycle("R6", 1, 1, 2'd1, 32'h0000_8000, 0, 1, 0, '0, '0);
    doCycle("R6", 1, 0, 2'd0, 0, 1, 1, 0, '0, '0);
    doCycle("R8", 1, 1, 2'd2, 32'h0002_0000, 1, 1, 1, 15'h0004, '0);
    doCycle("R8", 1, 0, 2'd0, 0, 1, 1, 1, 15'h0004, '0);
    doCycle("R8", 1, 0, 2'd0, 0, 1, 1, 1, 15'h0004, '0);
    doCycle("R8", 1, 0, 2'd0, 0, 1, 1, 0, '0, '0);
    doCycle("R8", 1, 0, 2'd0, 0, 1, 1, 0, '0, '0);
    doCycle("R9", 1, 1, 2'd3, 32'hFFFF_FFFF, 0, 0, 0, '0, '0);
    doCycle("R9", 1, 0, 2'd0, 0, 0, 0, 0, '0, '0);
    doCycle("R9", 1, 0, 2'd3, 0, 0, 0, 0, '0, '0);
    doCycle("R2", 1, 0, 2'd1, 0, 0, 0, 0, '0, 13'h1FFF);
    doCycle("R2", 1, 0, 2'd2, 0, 0, 0, 0, '0, 13'h1FFF);
    doCycle("R2", 1, 0, 2'd0, 0, 0, 0, 0, '0, 13'h1FFF);
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      doCycle("R7", r[0], r[1], r[3:2], $urandom, (r[7:4] == 0) ? ~timerIn : timerIn,
              (r[11:8] == 0) ? ~lvl15In : lvl15In, (r[15:12] == 0) ? ~masterOff : masterOff,
              15'($urandom & 32'h0000_1111), 13'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule